// File: doc/BRIEF.md
# Modulus Time Base with Single-Action Output Compare

This block is a small timer subsystem. A modulus channel counts prescaled ticks from 1 up to a programmed limit, wraps back to 1, and drives its count onto a shared time-base bus (bus A). A compare channel has no counter of its own. It watches either bus A or a second time-base bus supplied from outside the block (bus D). When the selected bus first reaches the programmed compare value, the channel sets a sticky flag and can toggle an output pin.

Software configures both channels through a plain write port. The configuration covers a global prescaler, a local prescaler per channel, the bus choice, the toggle action, the limit and compare values, and the freeze enables. The flag is cleared by writing 1 to it. A debug-freeze input halts a channel only when the global freeze bit and that channel's own freeze bit are both set. Because the compare channel reads a shared bus, a compare value above the modulus limit of bus A can never match.

Top module: `tmr_cmp_sys`

## Requirements
- R1: After reset, bus_a, cmp_flag and cmp_pin are all 0.
- R2: Register 0 holds the global prescaler. Bits [7:0] hold the divide value N, bit 8 enables the divider, and bit 9 enables the time base. With the divider enabled, a global tick occurs on every (N+1)th cycle. With the divider off, a tick occurs on every cycle. With bit 9 clear there are no ticks and bus_a holds its value.
- R3: Register 1 controls the modulus channel: bits [1:0] hold the local divide L, bit 2 enables the channel and bit 3 is its freeze enable. Register 2 holds the limit M. The channel advances on every (L+1)th global tick while enabled. The first step after reset loads 1. After that the count goes up by 1, and it loads 1 when the count is already at or above M. The count is driven on bus_a.
- R4: Register 3 bits [1:0] select the compare time base: 0 is bus_a and 1 is the bus_d input. Values 2 and 3 select an internal counter that does not exist, so no match ever occurs with them.
- R5: Register 3 bit 5 enables the compare channel, and bits [4:3] hold its local divide. Register 4 holds the compare value C. A match occurs on a compare-channel tick when the selected bus equals C and differs from the bus value seen on the previous compare tick. A match sets cmp_flag at the next clock edge, and the flag stays set.
- R6: When register 3 bit 2 is 1, each match inverts cmp_pin on the same edge that sets the flag. When the bit is 0, cmp_pin holds.
- R7: Writing register 5 with bit 0 set clears cmp_flag. Writing 0 to bit 0 has no effect. A match on the same edge as a clear wins.
- R8: With bus_a selected and C greater than M, cmp_flag is never set and cmp_pin never changes.
- R9: Register 0 bit 10 is the global freeze bit, and register 3 bit 6 is the compare channel's freeze enable. While dbg_freeze, the global freeze bit and a channel's freeze enable are all 1, that channel's prescaler, counter and compare logic hold their state. If either freeze bit is 0, the channel keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| dbg_freeze | input | 1 | Debug halt request |
| bus_d | input | 16 | Second time-base bus from another channel |
| bus_a | output | 16 | Modulus count, shared time-base bus A |
| cmp_flag | output | 1 | Sticky compare-match flag |
| cmp_pin | output | 1 | Compare output pin |

## Verification
A register write takes effect at the edge that samples it. The counters stepping at that same edge still use the old settings. A prescaled tick moves bus_a at the following edge. A match needs the new bus value to be present on a compare tick, so the flag and pin change one edge after that. The bench therefore keeps a cycle model that steps on each rising edge under the same rules, drives all inputs on the falling edge, and compares bus_a, cmp_flag and cmp_pin against that model on every falling edge. The directed checks for prescaling, freeze and the clear/ignore cases are placed at the same falling-edge points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_GLB  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MCTL = 3'd1;
  localparam logic [ADDR_W-1:0] A_MDAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CCTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CDAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {
    SEL_BUS_A = 2'd0,
    SEL_BUS_D = 2'd1,
    SEL_INT   = 2'd2,
    SEL_RSVD  = 2'd3
  } bus_sel_e;
endpackage

// File: rtl/tmr_gpresc.sv
module tmr_gpresc #(
  parameter int unsigned GPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tb_en,
  input  logic           div_en,
  input  logic [GPW-1:0] div,
  output logic           tick
);
  logic [GPW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = tb_en & (~div_en | (cnt_q >= div));
    cnt_d = cnt_q;
    if (!tb_en || tick) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_GTB_OFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/tmr_lpresc.sv
module tmr_lpresc #(
  parameter int unsigned LPW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gtick,
  input  logic           en,
  input  logic           frz,
  input  logic [LPW-1:0] div,
  output logic           tick
);
  logic [LPW-1:0] cnt_q, cnt_d;
  logic           run;

  always_comb begin
    run   = gtick & en & ~frz;
    tick  = run & (cnt_q >= div);
    cnt_d = cnt_q;
    if (!en)      cnt_d = '0;
    else if (run) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_LP_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && en) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/tmr_modch.sv
module tmr_modch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == '0 || cnt_q >= limit) cnt_d = ONE;
      else                               cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q != '0)); // R3
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q >= limit) |=> (cnt_q == ONE)); // R3
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/tmr_cmpch.sv
module tmr_cmpch
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  bus_sel_e         bsel,
  input  logic             tog_en,
  input  logic [CNT_W-1:0] cmpv,
  input  logic [CNT_W-1:0] bus_a,
  input  logic [CNT_W-1:0] bus_d,
  input  logic             clr,
  output logic             flag,
  output logic             pin
);
  logic [CNT_W-1:0] prev_q, prev_d, bus_v;
  logic             bus_ok, hit;
  logic             flag_q, flag_d, pin_q, pin_d;

  always_comb begin
    case (bsel)
      SEL_BUS_A: begin bus_v = bus_a; bus_ok = 1'b1; end
      SEL_BUS_D: begin bus_v = bus_d; bus_ok = 1'b1; end
      default:   begin bus_v = '0;    bus_ok = 1'b0; end
    endcase
    hit    = tick & bus_ok & (bus_v == cmpv) & (bus_v != prev_q);
    prev_d = tick ? bus_v : prev_q;
    flag_d = hit | (flag_q & ~clr);
    pin_d  = pin_q ^ (hit & tog_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  assign flag = flag_q;
  assign pin  = pin_q;

  AST_PIN_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_q) |-> flag_q); // R6
  AST_NO_TOGGLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_en |=> $stable(pin_q)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R7
  AST_NO_INTERNAL_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bsel[1] && !flag_q) |=> !flag_q); // R4
endmodule

// File: rtl/tmr_cmp_sys.sv
module tmr_cmp_sys
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned GPW   = 8,
  parameter int unsigned LPW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              dbg_freeze,
  input  logic [CNT_W-1:0]  bus_d,
  output logic [CNT_W-1:0]  bus_a,
  output logic              cmp_flag,
  output logic              cmp_pin
);
  localparam int unsigned NCH    = 2;
  localparam int unsigned CH_MOD = 0;
  localparam int unsigned CH_CMP = 1;
  localparam int unsigned G_EN   = GPW;
  localparam int unsigned G_TB   = GPW + 1;
  localparam int unsigned G_FRZ  = GPW + 2;
  localparam int unsigned M_EN   = LPW;
  localparam int unsigned M_FRZ  = LPW + 1;
  localparam int unsigned C_TOG  = 2;
  localparam int unsigned C_DIV  = 3;
  localparam int unsigned C_EN   = C_DIV + LPW;
  localparam int unsigned C_FRZ  = C_EN + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // configuration registers
  logic [GPW-1:0]   gdiv_q, gdiv_d;
  logic             gdiv_en_q, gdiv_en_d, tb_en_q, tb_en_d, gfrz_q, gfrz_d;
  logic [LPW-1:0]   m_div_q, m_div_d, c_div_q, c_div_d;
  logic             m_en_q, m_en_d, m_frz_q, m_frz_d;
  logic             c_en_q, c_en_d, c_frz_q, c_frz_d, c_tog_q, c_tog_d;
  bus_sel_e         c_bsel_q, c_bsel_d;
  logic [CNT_W-1:0] m_lim_q, m_lim_d, c_val_q, c_val_d;
  logic             flag_clr;

  always_comb begin
    gdiv_d = gdiv_q; gdiv_en_d = gdiv_en_q; tb_en_d = tb_en_q; gfrz_d = gfrz_q;
    m_div_d = m_div_q; m_en_d = m_en_q; m_frz_d = m_frz_q; m_lim_d = m_lim_q;
    c_bsel_d = c_bsel_q; c_tog_d = c_tog_q; c_div_d = c_div_q;
    c_en_d = c_en_q; c_frz_d = c_frz_q; c_val_d = c_val_q;
    if (wr_en) begin
      case (wr_addr)
        A_GLB: begin
          gdiv_d    = wr_data[GPW-1:0];
          gdiv_en_d = wr_data[G_EN];
          tb_en_d   = wr_data[G_TB];
          gfrz_d    = wr_data[G_FRZ];
        end
        A_MCTL: begin
          m_div_d = wr_data[LPW-1:0];
          m_en_d  = wr_data[M_EN];
          m_frz_d = wr_data[M_FRZ];
        end
        A_MDAT: m_lim_d = wr_data;
        A_CCTL: begin
          c_bsel_d = bus_sel_e'(wr_data[1:0]);
          c_tog_d  = wr_data[C_TOG];
          c_div_d  = wr_data[C_EN-1:C_DIV];
          c_en_d   = wr_data[C_EN];
          c_frz_d  = wr_data[C_FRZ];
        end
        A_CDAT: c_val_d = wr_data;
        default: ;
      endcase
    end
    flag_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      gdiv_q <= '0; gdiv_en_q <= 1'b0; tb_en_q <= 1'b0; gfrz_q <= 1'b0;
      m_div_q <= '0; m_en_q <= 1'b0; m_frz_q <= 1'b0; m_lim_q <= '0;
      c_bsel_q <= SEL_BUS_A; c_tog_q <= 1'b0; c_div_q <= '0;
      c_en_q <= 1'b0; c_frz_q <= 1'b0; c_val_q <= '0;
    end else begin
      gdiv_q <= gdiv_d; gdiv_en_q <= gdiv_en_d; tb_en_q <= tb_en_d; gfrz_q <= gfrz_d;
      m_div_q <= m_div_d; m_en_q <= m_en_d; m_frz_q <= m_frz_d; m_lim_q <= m_lim_d;
      c_bsel_q <= c_bsel_d; c_tog_q <= c_tog_d; c_div_q <= c_div_d;
      c_en_q <= c_en_d; c_frz_q <= c_frz_d; c_val_q <= c_val_d;
    end
  end

  // global prescaler
  logic gtick;
  tmr_gpresc #(.GPW(GPW)) u_gpresc (
    .clk    (clk),
    .rst_n  (rst_i),
    .tb_en  (tb_en_q),
    .div_en (gdiv_en_q),
    .div    (gdiv_q),
    .tick   (gtick)
  );

  // per-channel prescalers
  logic [LPW-1:0] ch_div [NCH];
  logic [NCH-1:0] ch_en, ch_frz, ch_tick;

  assign ch_div[CH_MOD] = m_div_q;
  assign ch_div[CH_CMP] = c_div_q;
  assign ch_en          = {c_en_q, m_en_q};
  assign ch_frz         = {c_frz_q, m_frz_q};

  for (genvar i = 0; i < NCH; i++) begin : g_lp
    tmr_lpresc #(.LPW(LPW)) u_lpresc (
      .clk   (clk),
      .rst_n (rst_i),
      .gtick (gtick),
      .en    (ch_en[i]),
      .frz   (dbg_freeze & gfrz_q & ch_frz[i]),
      .div   (ch_div[i]),
      .tick  (ch_tick[i])
    );
  end

  tmr_modch #(.CNT_W(CNT_W)) u_modch (
    .clk   (clk),
    .rst_n (rst_i),
    .tick  (ch_tick[CH_MOD]),
    .limit (m_lim_q),
    .cnt   (bus_a)
  );

  tmr_cmpch #(.CNT_W(CNT_W)) u_cmpch (
    .clk    (clk),
    .rst_n  (rst_i),
    .tick   (ch_tick[CH_CMP]),
    .bsel   (c_bsel_q),
    .tog_en (c_tog_q),
    .cmpv   (c_val_q),
    .bus_a  (bus_a),
    .bus_d  (bus_d),
    .clr    (flag_clr),
    .flag   (cmp_flag),
    .pin    (cmp_pin)
  );

  AST_TB_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !tb_en_q |=> $stable(bus_a)); // R2
endmodule

// File: tb/tmr_cmp_sys_test.sv
`timescale 1ns/1ps
module tmr_cmp_sys_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        dbg;
  logic [15:0] busd;
  logic [15:0] bus_a;
  logic        cmp_flag, cmp_pin;

  int n_chk = 0, n_bad = 0;
  bit chk_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cmp_sys uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_freeze(dbg), .bus_d(busd), .bus_a(bus_a), .cmp_flag(cmp_flag), .cmp_pin(cmp_pin)
  );

  // reference model state, stepped on each rising edge from the requirements
  int m_gdiv, m_gen, m_tben, m_gfrz, m_mdiv, m_men, m_mfrz, m_lim;
  int m_bsel, m_tog, m_cdiv, m_cen, m_cfrz, m_cmp;
  int m_gc, m_mlc, m_cnt, m_clc, m_prev, m_flag, m_pin;

  always @(posedge clk) begin : model
    int gt, mrun, mt, crun, ct, busv, ok, match, clr;
    if (!rst_n) begin
      m_gdiv = 0; m_gen = 0; m_tben = 0; m_gfrz = 0; m_mdiv = 0; m_men = 0; m_mfrz = 0;
      m_lim = 0; m_bsel = 0; m_tog = 0; m_cdiv = 0; m_cen = 0; m_cfrz = 0; m_cmp = 0;
      m_gc = 0; m_mlc = 0; m_cnt = 0; m_clc = 0; m_prev = 0; m_flag = 0; m_pin = 0;
    end else begin
      gt    = (m_tben != 0) && (m_gen == 0 || m_gc >= m_gdiv);
      mrun  = gt && m_men != 0 && !(dbg && m_gfrz != 0 && m_mfrz != 0);
      mt    = mrun && (m_mlc >= m_mdiv);
      crun  = gt && m_cen != 0 && !(dbg && m_gfrz != 0 && m_cfrz != 0);
      ct    = crun && (m_clc >= m_cdiv);
      ok    = (m_bsel < 2);
      busv  = (m_bsel == 0) ? m_cnt : ((m_bsel == 1) ? int'(busd) : 0);
      match = ct && ok && (busv == m_cmp) && (busv != m_prev);
      clr   = wr_en && wr_addr == 3'd5 && wr_data[0];
      m_gc  = (m_tben == 0 || gt) ? 0 : m_gc + 1;
      if (m_men == 0) m_mlc = 0; else if (mrun) m_mlc = mt ? 0 : m_mlc + 1;
      if (m_cen == 0) m_clc = 0; else if (crun) m_clc = ct ? 0 : m_clc + 1;
      if (mt) m_cnt = (m_cnt == 0 || m_cnt >= m_lim) ? 1 : m_cnt + 1;
      if (ct) m_prev = busv;
      m_flag = (match || (m_flag != 0 && !clr)) ? 1 : 0;
      if (match && m_tog != 0) m_pin = 1 - m_pin;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_gdiv = wr_data[7:0]; m_gen = wr_data[8]; m_tben = wr_data[9]; m_gfrz = wr_data[10]; end
          3'd1: begin m_mdiv = wr_data[1:0]; m_men = wr_data[2]; m_mfrz = wr_data[3]; end
          3'd2: m_lim = wr_data;
          3'd3: begin m_bsel = wr_data[1:0]; m_tog = wr_data[2]; m_cdiv = wr_data[4:3];
                      m_cen = wr_data[5]; m_cfrz = wr_data[6]; end
          3'd4: m_cmp = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R3 bus_a vs model", bus_a, m_cnt);
      chk("R5 cmp_flag vs model", cmp_flag, m_flag);
      chk("R6 cmp_pin vs model", cmp_pin, m_pin);
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int a0, p0;
    void'($urandom(32'd20240611));
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; dbg = 1'b0; busd = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 bus_a reset", bus_a, 0);
    chk("R1 cmp_flag reset", cmp_flag, 0);
    chk("R1 cmp_pin reset", cmp_pin, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;

    // R2: divide by 4 with limit 100
    wr(3'd2, 100);
    wr(3'd1, 16'h0004);
    wr(3'd0, (1 << 9) | (1 << 8) | 3);
    repeat (6) @(negedge clk);
    a0 = bus_a;
    repeat (8) @(negedge clk);
    chk("R2 two ticks in eight cycles", bus_a, a0 + 2);
    wr(3'd0, 0);
    a0 = bus_a;
    repeat (10) @(negedge clk);
    chk("R2 time base off holds", bus_a, a0);

    // R3: wrap at 5
    wr(3'd2, 5);
    wr(3'd0, 1 << 9);
    repeat (20) @(negedge clk);
    chk("R3 count within 1..5", (bus_a >= 1 && bus_a <= 5) ? 1 : 0, 1);

    // R5/R6: compare on bus A with toggle
    wr(3'd4, 3);
    wr(3'd3, (1 << 5) | (1 << 2));
    repeat (12) @(negedge clk);
    chk("R5 flag set on match", cmp_flag, 1);
    wr(3'd5, 0);
    chk("R7 write of 0 ignored", cmp_flag, 1);
    wr(3'd0, 0);
    wr(3'd5, 1);
    chk("R7 write of 1 clears", cmp_flag, 0);

    // R8: compare above limit
    wr(3'd4, 6);
    wr(3'd0, 1 << 9);
    p0 = cmp_pin;
    repeat (60) @(negedge clk);
    chk("R8 no flag above limit", cmp_flag, 0);
    chk("R8 no toggle above limit", cmp_pin, p0);

    // R6: toggle disabled
    wr(3'd4, 2);
    wr(3'd3, 1 << 5);
    p0 = cmp_pin;
    repeat (30) @(negedge clk);
    chk("R5 flag with toggle off", cmp_flag, 1);
    chk("R6 pin holds with toggle off", cmp_pin, p0);

    // R4: bus D
    wr(3'd0, 0);
    wr(3'd5, 1);
    wr(3'd3, (1 << 5) | (1 << 2) | 1);
    wr(3'd4, 7);
    wr(3'd0, 1 << 9);
    repeat (3) @(negedge clk);
    busd = 16'd7;
    @(negedge clk);
    chk("R4 match on bus_d", cmp_flag, 1);
    wr(3'd0, 0);
    wr(3'd5, 1);
    wr(3'd3, (1 << 5) | (1 << 2) | 2);
    wr(3'd0, 1 << 9);
    busd = 16'd0;
    repeat (2) @(negedge clk);
    busd = 16'd7;
    repeat (3) @(negedge clk);
    chk("R4 internal select never matches", cmp_flag, 0);

    // R9: freeze
    wr(3'd3, (1 << 5) | (1 << 6) | (1 << 2));
    wr(3'd1, 16'h000C);
    wr(3'd4, 3);
    wr(3'd0, (1 << 9) | (1 << 10));
    dbg = 1'b1;
    repeat (2) @(negedge clk);
    a0 = bus_a; p0 = cmp_pin;
    repeat (40) @(negedge clk);
    chk("R9 frozen count holds", bus_a, a0);
    chk("R9 frozen pin holds", cmp_pin, p0);
    dbg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 runs after release", (bus_a != a0) ? 1 : 0, 1);
    wr(3'd0, 1 << 9);
    dbg = 1'b1;
    a0 = bus_a;
    repeat (3) @(negedge clk);
    chk("R9 runs with global freeze off", (bus_a != a0) ? 1 : 0, 1);
    dbg = 1'b0;

    // random phase
    for (int i = 0; i < 20000; i++) begin
      int sel, d;
      wr_en = ($urandom % 16 == 0);
      sel = $urandom % 6;
      case (sel)
        0: d = ($urandom % 4) | (($urandom % 2) << 8) | ((($urandom % 8) != 0) << 9) | (($urandom % 2) << 10);
        1: d = ($urandom % 4) | ((($urandom % 8) != 0) << 2) | (($urandom % 2) << 3);
        2: d = 1 + ($urandom % 12);
        3: d = (($urandom % 3 == 0) ? ($urandom % 4) : 0) | (($urandom % 2) << 2) |
               (($urandom % 4) << 3) | ((($urandom % 8) != 0) << 5) | (($urandom % 2) << 6);
        4: d = $urandom % 15;
        default: d = $urandom % 2;
      endcase
      wr_addr = 3'(sel);
      wr_data = 16'(d);
      if ($urandom % 8 == 0) busd = 16'($urandom % 8);
      if ($urandom % 32 == 0) dbg = ~dbg;
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule